// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Change Interrupt

This block is one general-purpose I/O port of a register-mapped I/O expander. A host reaches it through a small synchronous register bus with an address, write and read strobes and a data byte. The port keeps what the host writes apart from what the pins report. Writes to the output register set the pin drive. Reads of the input register return the live pin levels, taken through a two-flop synchronizer and optionally inverted per bit. Because of this split, a pin driven weakly high can still be pulled low from outside and read back as low.

Any pin can take its data bit from an external PWM source instead of the output register. Each pin has a three-bit drive mode, which the block decodes into output-enable, pull-up, pull-down and slow-slew controls for the pad. A change on any synchronized input sets a sticky status bit. Reading the status register clears it. A mask register, whose 1 bits disable pins, selects which status bits pull the active-low interrupt line.

Top module: `gpio_port`

## Requirements
- R1: After synchronous active-low reset the registers hold these values: output 0xFF, invert 0x00, PWM select 0x00, mask 0xFF, status 0x00, all drive-mode planes 0 (every pin pulled-up). The read data is 0x00 and `irq_n` is 1. The synchronizer flops reset to all ones.
- R2: Read data is registered. The value at the address presented with `bus_rd` appears on `bus_rdata` after the next rising edge and holds until the next read. The writable registers read back the last written value: output (address 0), invert (2), PWM select (3), mask (4) and drive-mode planes 0..2 (6, 7, 8, holding mode bits 0, 1 and 2 of every pin). Other addresses read 0. Writes to addresses 1, 5 and 9..15 have no effect.
- R3: A read of address 1 returns the pin levels after two synchronizer flops, XORed with the invert register.
- R4: A pin's data bit is its `pwm_in` bit when its PWM select bit is 1, and its output-register bit otherwise.
- R5: Drive decode per pin, with d the data bit and `pad_out` = `pad_oe` & d:
  - mode 0 pulled-up: pu=1, oe=!d.
  - mode 1 pulled-down: pd=1, oe=d.
  - mode 2 open-drain high: oe=d.
  - mode 3 open-drain low: oe=!d.
  - modes 4 and 5 strong: oe=1.
  - modes 6 and 7 high-impedance: oe=pu=pd=0.
- R6: `pad_slow` is 1 only in mode 5.
- R7: When the synchronized value of a pin differs from its previous-cycle copy, its status bit sets. It then stays set until a status read (address 5), which returns the value held before the clear.
- R8: A status read clears every status bit, except that a change detected on the same edge leaves its bit set.
- R9: `irq_n` is 0 exactly when some status bit is 1 and its mask bit is 0. The mask does not stop status bits from setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_in | input | 8 | PWM source bit per pin |
| pin_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Value driven when enabled |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pull-up enable per pin |
| pad_pd | output | 8 | Pull-down enable per pin |
| pad_slow | output | 8 | Slow slew select per pin |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench times a pin change so that the detected event lands on the same edge as a status read. A design that applies the clear after the set would lose that event, leaving the status register and `irq_n` idle where the model expects them set. The bench also reads the input register straight after a pin change. A design with one synchronizer stage too few or too many returns the new level one cycle early or one cycle late. It also sweeps all eight drive modes against both data sources. A wrong decode of either weak-pull mode, or of the spare code 7, shows up as a wrong enable or pull on the pads. Writes to the read-only and unmapped addresses must leave every register unchanged; a design that decodes them loosely changes later read-backs.

// File: rtl/gpio_port_pkg.sv
// Package: shared address map and drive-mode encoding for the GPIO port.
// Assumes a 4-bit register address and 3-bit drive-mode codes.
package gpio_port_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_OUT    = 4'd0;
    localparam logic [ADDR_W-1:0] A_IN     = 4'd1;
    localparam logic [ADDR_W-1:0] A_INV    = 4'd2;
    localparam logic [ADDR_W-1:0] A_SEL    = 4'd3;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd5;
    localparam logic [ADDR_W-1:0] A_PLANE0 = 4'd6;

    localparam int MODE_BITS = 3;

    typedef enum logic [MODE_BITS-1:0] {
        DM_PULL_UP   = 3'd0,
        DM_PULL_DOWN = 3'd1,
        DM_OD_HIGH   = 3'd2,
        DM_OD_LOW    = 3'd3,
        DM_STRONG    = 3'd4,
        DM_STRONG_SL = 3'd5,
        DM_HIGH_Z    = 3'd6,
        DM_SPARE     = 3'd7
    } drive_mode_e;

endpackage

// File: rtl/gpio_port_regs.sv
// Module: host-visible register file and registered read path of the port.
// Holds output, invert, PWM select, mask and drive-mode planes. Produces a
// read-clear strobe for the status register. Read-only and unmapped
// addresses ignore writes.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    input  logic                       rd,
    input  logic [W-1:0]               wdata,
    input  logic [W-1:0]               pin_sync,
    input  logic [W-1:0]               status,
    output logic [W-1:0]               rdata,
    output logic [W-1:0]               out_q,
    output logic [W-1:0]               sel_q,
    output logic [W-1:0]               mask_q,
    output logic [MODE_BITS-1:0][W-1:0] plane_q,
    output logic                       stat_rd
);

    logic [W-1:0] inv_q;
    logic [W-1:0] rd_mux;

    // Plain configuration registers, written on a matching address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '1;
            inv_q  <= '0;
            sel_q  <= '0;
            mask_q <= '1;
        end else if (wr) begin
            if (addr == A_OUT)  out_q  <= wdata;
            if (addr == A_INV)  inv_q  <= wdata;
            if (addr == A_SEL)  sel_q  <= wdata;
            if (addr == A_MASK) mask_q <= wdata;
        end
    end

    // One drive-mode bit-plane per mode bit, at consecutive addresses.
    for (genvar p = 0; p < MODE_BITS; p++) begin : g_plane
        localparam logic [ADDR_W-1:0] PA = A_PLANE0 + ADDR_W'(p);
        // Bit-plane p: bit p of every pin's drive mode.
        always_ff @(posedge clk) begin
            if (!rst_n)                plane_q[p] <= '0;
            else if (wr && addr == PA) plane_q[p] <= wdata;
        end
    end

    // Select the addressed register for a read.
    always_comb begin
        rd_mux = '0;
        if (addr == A_OUT)       rd_mux = out_q;
        else if (addr == A_IN)   rd_mux = pin_sync ^ inv_q;
        else if (addr == A_INV)  rd_mux = inv_q;
        else if (addr == A_SEL)  rd_mux = sel_q;
        else if (addr == A_MASK) rd_mux = mask_q;
        else if (addr == A_STAT) rd_mux = status;
        else begin
            for (int p = 0; p < MODE_BITS; p++)
                if (addr == A_PLANE0 + ADDR_W'(p)) rd_mux = plane_q[p];
        end
    end

    // Capture read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    assign stat_rd = rd && (addr == A_STAT);

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/gpio_port_irq.sv
// Module: input synchronizer, change detector, sticky status and interrupt.
// Assumes pins are idle high at reset (synchronizer resets to ones). A change
// on the same edge as a status read survives the clear.
module gpio_port_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic         stat_rd,
    input  logic [W-1:0] mask_q,
    output logic [W-1:0] pin_sync,
    output logic [W-1:0] status,
    output logic         irq_n
);

    logic [W-1:0] meta_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] chg;

    // Two-flop synchronizer plus a one-cycle history copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '1;
            pin_sync <= '1;
            prev_q   <= '1;
        end else begin
            meta_q   <= pin_in;
            pin_sync <= meta_q;
            prev_q   <= pin_sync;
        end
    end

    assign chg = pin_sync ^ prev_q;

    // Sticky status: clear on read, new events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (stat_rd ? '0 : status) | chg;
    end

    assign irq_n = ~|(status & ~mask_q);

    // R7
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((status & $past(chg)) == $past(chg)));

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> ((status & ~$past(chg)) == '0));

endmodule

// File: rtl/gpio_port_pad.sv
// Module: per-pin drive decode from mode code and data bit to pad controls.
// Purely combinational; data bit is PWM or output register per select bit.
module gpio_port_pad
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [W-1:0]                out_q,
    input  logic [W-1:0]                sel_q,
    input  logic [W-1:0]                pwm_in,
    input  logic [MODE_BITS-1:0][W-1:0] plane_q,
    output logic [W-1:0]                pad_out,
    output logic [W-1:0]                pad_oe,
    output logic [W-1:0]                pad_pu,
    output logic [W-1:0]                pad_pd,
    output logic [W-1:0]                pad_slow
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        drive_mode_e mode;
        logic        d, oe, pu, pd, slow;

        assign mode = drive_mode_e'({plane_q[2][i], plane_q[1][i], plane_q[0][i]});
        assign d    = sel_q[i] ? pwm_in[i] : out_q[i];

        // Decode this pin's mode into enable, pulls and slew.
        always_comb begin
            oe = 1'b0; pu = 1'b0; pd = 1'b0; slow = 1'b0;
            case (mode)
                DM_PULL_UP:   begin pu = 1'b1; oe = !d; end
                DM_PULL_DOWN: begin pd = 1'b1; oe = d;  end
                DM_OD_HIGH:   oe = d;
                DM_OD_LOW:    oe = !d;
                DM_STRONG:    oe = 1'b1;
                DM_STRONG_SL: begin oe = 1'b1; slow = 1'b1; end
                default:      oe = 1'b0;
            endcase
        end

        assign pad_out[i]  = oe & d;
        assign pad_oe[i]   = oe;
        assign pad_pu[i]   = pu;
        assign pad_pd[i]   = pd;
        assign pad_slow[i] = slow;
    end

    // R5
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R6
    slow_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_slow & ~pad_oe) == '0);

endmodule

// File: rtl/gpio_port.sv
// Module: top of one GPIO port: register file, interrupt logic, pad decode.
// Assumes a single clock domain for the bus; pins are asynchronous.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pwm_in,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu,
    output logic [WIDTH-1:0]  pad_pd,
    output logic [WIDTH-1:0]  pad_slow,
    output logic              irq_n
);

    logic [WIDTH-1:0]                out_q, sel_q, mask_q, pin_sync, status;
    logic [MODE_BITS-1:0][WIDTH-1:0] plane_q;
    logic                            stat_rd;

    gpio_port_regs #(.W(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .pin_sync(pin_sync), .status(status),
        .rdata(bus_rdata), .out_q(out_q), .sel_q(sel_q), .mask_q(mask_q),
        .plane_q(plane_q), .stat_rd(stat_rd)
    );

    gpio_port_irq #(.W(WIDTH)) u_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .stat_rd(stat_rd),
        .mask_q(mask_q), .pin_sync(pin_sync), .status(status), .irq_n(irq_n)
    );

    gpio_port_pad #(.W(WIDTH)) u_pad (
        .clk(clk), .rst_n(rst_n), .out_q(out_q), .sel_q(sel_q), .pwm_in(pwm_in),
        .plane_q(plane_q), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_slow(pad_slow)
    );

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> irq_n);

endmodule

// File: tb/gpio_port_test.sv
// Bench: behavioural reference model compared against the port on every clock.
module gpio_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, pwm_in = '0, pin_in = 8'hFF;
    logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu, pad_pd, pad_slow;
    logic       irq_n;

    int  total = 0, bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_in(pwm_in), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_slow(pad_slow), .irq_n(irq_n)
    );

    // Reference state
    logic [7:0] m_out, m_inv, m_sel, m_mask, m_stat, m_rdata, ev;
    logic [7:0] m_plane [3];
    logic [7:0] pipe [$];
    int         last_addr;

    function automatic logic [7:0] mread(int a);
        case (a)
            0: return m_out;
            1: return pipe[1] ^ m_inv;
            2: return m_inv;
            3: return m_sel;
            4: return m_mask;
            5: return m_stat;
            6: return m_plane[0];
            7: return m_plane[1];
            8: return m_plane[2];
            default: return 8'h00;
        endcase
    endfunction

    // Advance the model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 8'hFF; m_inv = 0; m_sel = 0; m_mask = 8'hFF; m_stat = 0;
            m_rdata = 0; last_addr = 0;
            for (int p = 0; p < 3; p++) m_plane[p] = 0;
            pipe = {8'hFF, 8'hFF, 8'hFF};
        end else begin
            ev = pipe[1] ^ pipe[2];
            if (bus_rd) begin
                m_rdata = mread(int'(bus_addr));
                last_addr = int'(bus_addr);
            end
            if (bus_rd && bus_addr == 4'd5) m_stat = 0;
            m_stat = m_stat | ev;
            pipe.push_front(pin_in);
            void'(pipe.pop_back());
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: m_out = bus_wdata;
                    2: m_inv = bus_wdata;
                    3: m_sel = bus_wdata;
                    4: m_mask = bus_wdata;
                    6, 7, 8: m_plane[int'(bus_addr) - 6] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs 3 ns after every rising edge, away from both edges.
    always @(posedge clk) begin
        #3;
        begin
            logic [7:0] e_out, e_oe, e_pu, e_pd, e_sl;
            string rq;
            for (int i = 0; i < 8; i++) begin
                int  md;
                bit  d;
                md = {m_plane[2][i], m_plane[1][i], m_plane[0][i]};
                d  = m_sel[i] ? pwm_in[i] : m_out[i];   // R4
                e_oe[i] = 0; e_pu[i] = 0; e_pd[i] = 0; e_sl[i] = 0;
                if (md == 0)      begin e_pu[i] = 1; e_oe[i] = !d; end
                else if (md == 1) begin e_pd[i] = 1; e_oe[i] = d; end
                else if (md == 2) e_oe[i] = d;
                else if (md == 3) e_oe[i] = !d;
                else if (md == 4) e_oe[i] = 1;
                else if (md == 5) begin e_oe[i] = 1; e_sl[i] = 1; end
                e_out[i] = e_oe[i] && d;
            end
            if (!rst_n) rq = "R1";
            else if (last_addr == 1) rq = "R3";
            else if (last_addr == 5) rq = "R7 R8";
            else rq = "R2";
            chk(rq, "bus_rdata", bus_rdata, m_rdata);
            chk("R4 R5", "pad_out", pad_out, e_out);
            chk("R5", "pad_oe", pad_oe, e_oe);
            chk("R5", "pad_pu", pad_pu, e_pu);
            chk("R5", "pad_pd", pad_pd, e_pd);
            chk("R6", "pad_slow", pad_slow, e_sl);
            chk("R9", "irq_n", {7'd0, irq_n}, {7'd0, ~|(m_stat & ~m_mask)});
        end
    end

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk); bus_addr = 4'(a); bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(int a);
        @(negedge clk); bus_addr = 4'(a); bus_rd = 1;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        idle(3); rst_n = 1; idle(1);
        for (int a = 0; a < 16; a++) rd(a);
        // R2: write every address, read all back
        wr(0, 8'h5A); wr(2, 8'h0F); wr(3, 8'h00); wr(4, 8'hC3);
        wr(6, 8'h11); wr(7, 8'h22); wr(8, 8'h44);
        wr(1, 8'h00); wr(5, 8'hFF); wr(9, 8'h77); wr(15, 8'h99);
        for (int a = 0; a < 16; a++) rd(a);
        wr(4, 8'hFF); wr(6, 0); wr(7, 0); wr(8, 0); wr(0, 8'hFF);
        // R3: input sampling with inversion and synchronizer latency
        wr(2, 8'hA5); pin_in = 8'h3C; idle(3); rd(1);
        pin_in = 8'h00; rd(1); rd(1); rd(1);
        wr(2, 8'h00); rd(1); pin_in = 8'hFF; idle(3); rd(1);
        rd(5); idle(2);
        // R4 R5 R6: every drive mode against register and PWM data
        for (int m = 0; m < 8; m++) begin
            wr(6, {8{m[0]}}); wr(7, {8{m[1]}}); wr(8, {8{m[2]}});
            wr(0, 8'hA5); wr(3, 8'h0F);
            for (int k = 0; k < 4; k++) begin pwm_in = 8'(k * 8'h55); idle(1); end
            wr(0, 8'h5A); wr(3, 8'hF0); pwm_in = 8'h3C; idle(2);
        end
        wr(6, 0); wr(7, 0); wr(8, 0); wr(3, 0); wr(0, 8'hFF);
        // R7 R9: masked pins set status but do not raise the interrupt
        wr(4, 8'hF0); pin_in = 8'h7F; idle(4); rd(5);
        pin_in = 8'h7E; idle(4); rd(5); idle(2); rd(5);
        // R8: events placed on and around the read-clear edge
        for (int off = 0; off < 5; off++) begin
            pin_in = pin_in ^ 8'h01;
            idle(off); rd(5); idle(4); rd(5); idle(1);
        end
        // R9: all pins unmasked, multi-bit changes
        wr(4, 8'h00); pin_in = 8'hA5; idle(4); rd(5); idle(2);
        pin_in = 8'h5A; idle(1); rd(5); rd(5); idle(3); rd(5); idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule